// File: doc/BRIEF.md
# Mailbox Command Register with Busy Handshake

This block is the device side of a host-visible command mailbox. The host writes one 128-bit command in a single register write to the mailbox offset. The command carries a control word (an opcode, an event flag, a direction flag, a busy flag and a queue number) and a 64-bit context address. The control word occupies bits [31:0] of the write. The address low word sits in [63:32] and the address high word in [95:64]. Bits [127:96] are reserved and ignored.

Once a command is accepted, the block holds busy high and runs the command against a context store. It does this by presenting a single request on a valid/ready memory-request port. After the request completes, the block drops busy and publishes a completion status. The host serialises its commands by polling the busy bit before and after each issue. A command written while the mailbox is still busy is dropped, and this is recorded in a sticky error flag.

Top module: `mbx_cmd_reg`

## Requirements
- R1: After synchronous reset the block is idle: busy_o=0, status_o=0, err_o=0, mreq_valid_o=0 and ctl_word_o=0.
- R2: A write with host_wr_en=1, host_addr equal to MBX_OFFSET (default 0x300) and data bit 13 (busy) set is accepted when idle. In the following cycle busy_o=1 and ctl_word_o is laid out as follows:
  - opcode in [7:0]
  - event flag in [8]
  - status in [12:9], equal to 0
  - busy in [13], equal to 1
  - direction in [14]
  - zero in [15]
  - queue number in [31:16]
- R3: Opcodes 0 to 5 are valid. For a valid opcode, mreq_valid_o rises in the cycle after acceptance with the following fields:
  - mreq_addr_o = {data[95:64], data[63:32]}
  - mreq_kind_o = opcode
  - mreq_queue_o = queue number
  - mreq_write_o = direction bit
  - mreq_event_o = event bit
- R4: While mreq_valid_o=1 and mreq_ready_i=0, the request stays asserted and all of its fields stay unchanged.
- R5: For a handshake (mreq_valid_o and mreq_ready_i both 1 at a clock edge):
  - mreq_valid_o drops at that edge.
  - busy_o stays 1 for exactly one more cycle and then clears.
  - status_o becomes 0 when busy_o clears.
- R6: An opcode above 5 never raises mreq_valid_o. busy_o clears one cycle after acceptance with status_o=1.
- R7: A busy-flagged write to MBX_OFFSET while busy_o=1 is ignored, and err_o is set. The running command's queue number, opcode and request address stay unchanged.
- R8: Writes to any other address, or to MBX_OFFSET with bit 13 clear, start nothing and leave err_o unchanged.
- R9: Once set, err_o stays at 1 through later commands until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_addr | input | ADDR_W | Host register write offset |
| host_wdata | input | 128 | Host write data (command) |
| ctl_word_o | output | 32 | Live control word as read back by the host |
| busy_o | output | 1 | Command in progress |
| status_o | output | 4 | Completion status, 0 = success, 1 = unknown opcode |
| err_o | output | 1 | Sticky flag: command written while busy |
| mreq_valid_o | output | 1 | Context memory request valid |
| mreq_ready_i | input | 1 | Context memory request accepted |
| mreq_write_o | output | 1 | Request direction, 1 = write context |
| mreq_event_o | output | 1 | Event flag of the command |
| mreq_kind_o | output | 8 | Opcode (context kind) of the request |
| mreq_queue_o | output | 16 | Queue number of the request |
| mreq_addr_o | output | 64 | Context address |

## Verification
The hardest situation to reach is a second command colliding with one in progress. Only that case exercises both the drop and the sticky error.

To reach it, the stimulus holds mreq_ready_i low so that the first command parks in its request phase. It then writes a different command and checks that the queue number, opcode and address are unchanged.

A vector table sweeps every valid opcode and two invalid ones. For each vector it varies the number of stall cycles before the handshake, which probes the one-cycle busy tail after every handshake.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  // Control word field positions; the host decodes these when polling.
  localparam int OPC_LSB  = 0;
  localparam int OPC_W    = 8;
  localparam int EVT_BIT  = 8;
  localparam int STS_LSB  = 9;
  localparam int STS_W    = 4;
  localparam int BUSY_BIT = 13;
  localparam int DIR_BIT  = 14;
  localparam int QNUM_LSB = 16;
  localparam int QNUM_W   = 16;
  localparam int CADDR_W  = 64;
  localparam int CMD_W    = 128;

  localparam int OPC_MAX  = 5;

  localparam logic [STS_W-1:0] STS_OK      = 4'h0;
  localparam logic [STS_W-1:0] STS_BAD_OPC = 4'h1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_DONE = 2'd2
  } mbx_state_e;

  typedef struct packed {
    logic [QNUM_W-1:0]  qnum;
    logic               dir;
    logic               evt;
    logic [OPC_W-1:0]   opc;
    logic [CADDR_W-1:0] caddr;
  } mbx_cmd_t;

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] MBX_OFFSET = 12'h300
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CMD_W-1:0]  wdata,
  output logic              start,
  output logic              opc_ok,
  output mbx_cmd_t          cmd
);

  logic hit;
  logic unused_rsvd;

  assign hit   = wr_en && (addr == MBX_OFFSET);
  assign start = hit && wdata[BUSY_BIT];

  assign cmd.opc   = wdata[OPC_LSB +: OPC_W];
  assign cmd.evt   = wdata[EVT_BIT];
  assign cmd.dir   = wdata[DIR_BIT];
  assign cmd.qnum  = wdata[QNUM_LSB +: QNUM_W];
  assign cmd.caddr = {wdata[95:64], wdata[63:32]};

  assign opc_ok = (cmd.opc <= OPC_W'(OPC_MAX));

  // Status bits written by the host and the reserved word carry no meaning.
  assign unused_rsvd = ^{wdata[127:96], wdata[15], wdata[STS_LSB +: STS_W]};

endmodule

// File: rtl/mbx_cmd_store.sv
module mbx_cmd_store
  import mbx_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     load,
  input  mbx_cmd_t cmd_in,
  output mbx_cmd_t cmd_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
    end else if (load) begin
      cmd_q <= cmd_in;
    end
  end

endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             opc_ok,
  input  logic             req_ready,
  output logic             accept,
  output logic             req_valid,
  output logic             busy_q,
  output logic [STS_W-1:0] status_q,
  output logic             err_q
);

  mbx_state_e       state;
  logic [STS_W-1:0] pend_sts;

  assign accept    = start && (state == ST_IDLE);
  assign req_valid = (state == ST_REQ);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      busy_q   <= 1'b0;
      status_q <= STS_OK;
      pend_sts <= STS_OK;
      err_q    <= 1'b0;
    end else begin
      if (start && state != ST_IDLE) begin
        err_q <= 1'b1;
      end
      case (state)
        ST_IDLE: begin
          if (start) begin
            busy_q   <= 1'b1;
            status_q <= STS_OK;
            if (opc_ok) begin
              state    <= ST_REQ;
              pend_sts <= STS_OK;
            end else begin
              state    <= ST_DONE;
              pend_sts <= STS_BAD_OPC;
            end
          end
        end
        ST_REQ: begin
          if (req_ready) begin
            state <= ST_DONE;
          end
        end
        ST_DONE: begin
          state    <= ST_IDLE;
          busy_q   <= 1'b0;
          status_q <= pend_sts;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mbx_cmd_reg.sv
module mbx_cmd_reg
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] MBX_OFFSET = 12'h300
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                host_wr_en,
  input  logic [ADDR_W-1:0]   host_addr,
  input  logic [CMD_W-1:0]    host_wdata,
  output logic [31:0]         ctl_word_o,
  output logic                busy_o,
  output logic [STS_W-1:0]    status_o,
  output logic                err_o,
  output logic                mreq_valid_o,
  input  logic                mreq_ready_i,
  output logic                mreq_write_o,
  output logic                mreq_event_o,
  output logic [OPC_W-1:0]    mreq_kind_o,
  output logic [QNUM_W-1:0]   mreq_queue_o,
  output logic [CADDR_W-1:0]  mreq_addr_o
);

  logic     start;
  logic     opc_ok;
  logic     accept;
  mbx_cmd_t cmd_in;
  mbx_cmd_t cmd_q;

  mbx_decode #(
    .ADDR_W    (ADDR_W),
    .MBX_OFFSET(MBX_OFFSET)
  ) u_decode (
    .wr_en (host_wr_en),
    .addr  (host_addr),
    .wdata (host_wdata),
    .start (start),
    .opc_ok(opc_ok),
    .cmd   (cmd_in)
  );

  mbx_cmd_store u_store (
    .clk   (clk),
    .rst   (rst),
    .load  (accept),
    .cmd_in(cmd_in),
    .cmd_q (cmd_q)
  );

  mbx_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .opc_ok   (opc_ok),
    .req_ready(mreq_ready_i),
    .accept   (accept),
    .req_valid(mreq_valid_o),
    .busy_q   (busy_o),
    .status_q (status_o),
    .err_q    (err_o)
  );

  assign ctl_word_o = {cmd_q.qnum, 1'b0, cmd_q.dir, busy_o, status_o,
                       cmd_q.evt, cmd_q.opc};

  assign mreq_write_o = cmd_q.dir;
  assign mreq_event_o = cmd_q.evt;
  assign mreq_kind_o  = cmd_q.opc;
  assign mreq_queue_o = cmd_q.qnum;
  assign mreq_addr_o  = cmd_q.caddr;

endmodule

// File: rtl/mbx_cmd_reg_chk.sv
module mbx_cmd_reg_chk
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] MBX_OFFSET = 12'h300
) (
  input logic                clk,
  input logic                rst,
  input logic                host_wr_en,
  input logic [ADDR_W-1:0]   host_addr,
  input logic [CMD_W-1:0]    host_wdata,
  input logic [31:0]         ctl_word_o,
  input logic                busy_o,
  input logic [STS_W-1:0]    status_o,
  input logic                err_o,
  input logic                mreq_valid_o,
  input logic                mreq_ready_i,
  input logic [CADDR_W-1:0]  mreq_addr_o
);

  logic cmd_wr;
  logic unused_chk;

  assign cmd_wr     = host_wr_en && host_addr == MBX_OFFSET && host_wdata[BUSY_BIT];
  assign unused_chk = ^{host_wdata, status_o};

  // R3: a request only runs inside a busy window
  a_r3_req_in_busy: assert property (@(posedge clk) disable iff (rst)
    mreq_valid_o |-> busy_o);

  // R4: stalled request holds its fields
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    mreq_valid_o && !mreq_ready_i |=> mreq_valid_o && $stable(mreq_addr_o)
                                      && $stable(ctl_word_o[31:16]));

  // R5: busy tail of exactly one cycle after handshake
  a_r5_busy_tail: assert property (@(posedge clk) disable iff (rst)
    mreq_valid_o && mreq_ready_i |=> busy_o && !mreq_valid_o ##1 !busy_o);

  // R6: only valid opcodes reach the memory port
  a_r6_no_bad_req: assert property (@(posedge clk) disable iff (rst)
    mreq_valid_o |-> ctl_word_o[OPC_LSB +: OPC_W] <= OPC_W'(OPC_MAX));

  // R7: collision sets the error and keeps the running command
  a_r7_collide: assert property (@(posedge clk) disable iff (rst)
    cmd_wr && busy_o |=> err_o && $stable(ctl_word_o[31:16])
                         && $stable(ctl_word_o[7:0]));

  // R8: no collision leaves the error clear
  a_r8_no_spurious_err: assert property (@(posedge clk) disable iff (rst)
    !err_o && !(cmd_wr && busy_o) |=> !err_o);

  // R9: the error is sticky
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o);

endmodule

bind mbx_cmd_reg mbx_cmd_reg_chk #(
  .ADDR_W    (ADDR_W),
  .MBX_OFFSET(MBX_OFFSET)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .host_wr_en  (host_wr_en),
  .host_addr   (host_addr),
  .host_wdata  (host_wdata),
  .ctl_word_o  (ctl_word_o),
  .busy_o      (busy_o),
  .status_o    (status_o),
  .err_o       (err_o),
  .mreq_valid_o(mreq_valid_o),
  .mreq_ready_i(mreq_ready_i),
  .mreq_addr_o (mreq_addr_o)
);

// File: tb/mbx_cmd_reg_tb.sv
`timescale 1ns/1ps
module mbx_cmd_reg_tb;

  localparam int ADDR_W = 12;
  localparam logic [ADDR_W-1:0] OFFS = 12'h300;

  typedef struct packed {
    logic [7:0]  opc;
    logic [15:0] q;
    logic        dir;
    logic        evt;
    logic [63:0] addr;
    logic [3:0]  dly;
    logic [3:0]  sts;
  } vec_t;

  localparam vec_t VEC [0:7] = '{
    '{8'd0,   16'h0001, 1'b0, 1'b0, 64'h0000_0000_1000_0000, 4'd0, 4'd0},
    '{8'd1,   16'h00A5, 1'b1, 1'b0, 64'hDEAD_BEEF_0000_1000, 4'd2, 4'd0},
    '{8'd2,   16'hFFFF, 1'b0, 1'b1, 64'h0000_0000_0000_0001, 4'd5, 4'd0},
    '{8'd3,   16'h0000, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFF0, 4'd1, 4'd0},
    '{8'd4,   16'h1234, 1'b0, 1'b0, 64'h8000_0000_0000_0000, 4'd3, 4'd0},
    '{8'd5,   16'h4321, 1'b1, 1'b0, 64'h0123_4567_89AB_CDEF, 4'd0, 4'd0},
    '{8'd6,   16'h0042, 1'b0, 1'b0, 64'h0000_0000_0000_0055, 4'd0, 4'd1},
    '{8'hFF,  16'h7777, 1'b1, 1'b1, 64'h0000_0000_0000_00AA, 4'd0, 4'd1}
  };

  logic              clk = 1'b0;
  logic              rst;
  logic              host_wr_en;
  logic [ADDR_W-1:0] host_addr;
  logic [127:0]      host_wdata;
  logic [31:0]       ctl_word_o;
  logic              busy_o;
  logic [3:0]        status_o;
  logic              err_o;
  logic              mreq_valid_o;
  logic              mreq_ready_i;
  logic              mreq_write_o;
  logic              mreq_event_o;
  logic [7:0]        mreq_kind_o;
  logic [15:0]       mreq_queue_o;
  logic [63:0]       mreq_addr_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  mbx_cmd_reg #(.ADDR_W(ADDR_W), .MBX_OFFSET(OFFS)) u_dut (
    .clk(clk), .rst(rst), .host_wr_en(host_wr_en), .host_addr(host_addr),
    .host_wdata(host_wdata), .ctl_word_o(ctl_word_o), .busy_o(busy_o),
    .status_o(status_o), .err_o(err_o), .mreq_valid_o(mreq_valid_o),
    .mreq_ready_i(mreq_ready_i), .mreq_write_o(mreq_write_o),
    .mreq_event_o(mreq_event_o), .mreq_kind_o(mreq_kind_o),
    .mreq_queue_o(mreq_queue_o), .mreq_addr_o(mreq_addr_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] mk_cmd(input vec_t v, input logic busy);
    return {32'h0, v.addr[63:32], v.addr[31:0], v.q, 1'b0, v.dir, busy, 4'h0, v.evt, v.opc};
  endfunction

  function automatic logic [31:0] exp_ctl(input vec_t v, input logic busy, input logic [3:0] sts);
    return {v.q, 1'b0, v.dir, busy, sts, v.evt, v.opc};
  endfunction

  // Drive one write at a falling edge; returns at the falling edge after it is sampled.
  task automatic host_write(input logic [ADDR_W-1:0] a, input logic [127:0] d);
    host_wr_en = 1'b1;
    host_addr  = a;
    host_wdata = d;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic idle_checks(input string req);
    chk(req, {63'h0, busy_o}, 64'h0);
    chk(req, {63'h0, mreq_valid_o}, 64'h0);
    chk(req, {60'h0, status_o}, 64'h0);
    chk(req, {63'h0, err_o}, 64'h0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    host_wr_en   = 1'b0;
    host_addr    = '0;
    host_wdata   = '0;
    mreq_ready_i = 1'b0;
    do_reset();
    idle_checks("R1");
    chk("R1", {32'h0, ctl_word_o}, 64'h0);

    for (int i = 0; i < 8; i++) begin
      vec_t v;
      logic good;
      v = VEC[i];
      good = (v.opc <= 8'd5);
      host_write(OFFS, mk_cmd(v, 1'b1));
      chk("R2", {63'h0, busy_o}, 64'h1);
      chk("R2", {32'h0, ctl_word_o}, {32'h0, exp_ctl(v, 1'b1, 4'h0)});
      if (good) begin
        chk("R3", {63'h0, mreq_valid_o}, 64'h1);
        chk("R3", mreq_addr_o, v.addr);
        chk("R3", {40'h0, mreq_kind_o, mreq_queue_o},
            {40'h0, v.opc, v.q});
        chk("R3", {62'h0, mreq_write_o, mreq_event_o}, {62'h0, v.dir, v.evt});
        for (int d = 0; d < int'(v.dly); d++) begin
          @(negedge clk);
          chk("R4", {63'h0, mreq_valid_o}, 64'h1);
          chk("R4", mreq_addr_o, v.addr);
        end
        mreq_ready_i = 1'b1;
        @(negedge clk);
        mreq_ready_i = 1'b0;
        chk("R5", {63'h0, mreq_valid_o}, 64'h0);
        chk("R5", {63'h0, busy_o}, 64'h1);
        @(negedge clk);
        chk("R5", {63'h0, busy_o}, 64'h0);
        chk("R5", {60'h0, status_o}, {60'h0, v.sts});
      end else begin
        chk("R6", {63'h0, mreq_valid_o}, 64'h0);
        @(negedge clk);
        chk("R6", {63'h0, busy_o}, 64'h0);
        chk("R6", {63'h0, mreq_valid_o}, 64'h0);
        chk("R6", {60'h0, status_o}, {60'h0, v.sts});
        chk("R6", {32'h0, ctl_word_o}, {32'h0, exp_ctl(v, 1'b0, v.sts)});
      end
      chk("R8", {63'h0, err_o}, 64'h0);
    end

    // R8: wrong offset and busy bit clear start nothing
    host_write(OFFS + 12'h4, mk_cmd(VEC[0], 1'b1));
    chk("R8", {63'h0, busy_o}, 64'h0);
    chk("R8", {63'h0, mreq_valid_o}, 64'h0);
    host_write(OFFS, mk_cmd(VEC[1], 1'b0));
    chk("R8", {63'h0, busy_o}, 64'h0);
    chk("R8", {63'h0, err_o}, 64'h0);

    // R7: collision while stalled in the request phase
    host_write(OFFS, mk_cmd(VEC[1], 1'b1));
    chk("R7", {63'h0, mreq_valid_o}, 64'h1);
    host_write(OFFS, mk_cmd(VEC[4], 1'b1));
    chk("R7", {63'h0, err_o}, 64'h1);
    chk("R7", {48'h0, mreq_queue_o}, {48'h0, VEC[1].q});
    chk("R7", {56'h0, mreq_kind_o}, {56'h0, VEC[1].opc});
    chk("R7", mreq_addr_o, VEC[1].addr);
    chk("R7", {63'h0, mreq_valid_o}, 64'h1);
    mreq_ready_i = 1'b1;
    @(negedge clk);
    mreq_ready_i = 1'b0;
    @(negedge clk);
    chk("R5", {63'h0, busy_o}, 64'h0);
    chk("R9", {63'h0, err_o}, 64'h1);

    // R9: error survives another full command
    host_write(OFFS, mk_cmd(VEC[6], 1'b1));
    @(negedge clk);
    chk("R9", {63'h0, err_o}, 64'h1);
    chk("R6", {60'h0, status_o}, 64'h1);

    // R1: reset clears everything again
    do_reset();
    idle_checks("R1");
    chk("R1", {32'h0, ctl_word_o}, 64'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule